// File: doc/BRIEF.md
# Host Mailbox Port

This block is a slave port through which an external host processor reaches a small bank of mailbox registers as if they were memory-mapped words. The host presents a chip-select, an address and read or write strobes; the block decodes the access, latches the address, moves the data and drives an acknowledge. On the other side, the core reaches the same registers through a plain read/write port and sees one full flag per register.

Two mode inputs are sampled at run time. The first chooses where the address comes from. It can arrive on dedicated address pins, or it can be time-multiplexed on the data bus and captured by an address-latch-enable pulse. The second chooses the strobe style. One style uses separate read and write strobes. The other uses one data strobe together with a direction line.

Every host control pin passes through a synchroniser into the core clock. The address and data pins pass through a delay line of the same depth, so that each value lines up with the strobe edge it belongs to. The register space is split into two halves. The lower half holds inbound registers, which the host writes and the core reads. The upper half holds outbound registers, which the core writes and the host reads.

Top module: `host_mailbox_port`

## Requirements
- R1: While reset is held, every inbound and outbound full flag is 0, the acknowledge is low and the bus output enable is low.
- R2: With the address mode at 0 (separate pins) and the strobe mode at 0, a host write stores the bus value seen on the last sample before the write strobe or the chip-select rose. It goes to the inbound register chosen by `h_addr` (index = address bits below the top bit, top bit 0) and sets that register's inbound flag.
- R3: With the address mode at 1 (multiplexed), the register address is the low address bits of the bus on the last sample before `h_ale` fell. `h_addr` is ignored.
- R4: With the strobe mode at 1, an access is a read when `h_dir` is 1 and a write when `h_dir` is 0, timed by `h_ds_n`. `h_rd_n` and `h_wr_n` are ignored in that mode.
- R5: An access exists only while `h_cs_n` and the active strobe are both low. A strobe without the chip-select, or the chip-select without a strobe, writes nothing, changes no flag and raises no acknowledge.
- R6: The acknowledge rises while an access is active and falls once its end is seen. During a read, the output enable is high and `h_bus_o` holds the addressed register whenever the acknowledge is high.
- R7: A host read of an outbound register (top address bit 1) returns its contents and clears its outbound flag once the read ends. A host read of an inbound register returns its contents and changes no flag.
- R8: A core write to an outbound address sets that register's outbound flag. A core read of an inbound address returns its contents combinationally and clears its inbound flag.
- R9: A host write to an outbound address, and a core write to an inbound address, change no register contents and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mode_i | input | 1 | 0: address on `h_addr`; 1: address multiplexed on the bus |
| stb_mode_i | input | 1 | 0: separate read/write strobes; 1: direction plus data strobe |
| h_cs_n | input | 1 | Host chip-select, active low |
| h_rd_n | input | 1 | Host read strobe (strobe mode 0) |
| h_wr_n | input | 1 | Host write strobe (strobe mode 0) |
| h_dir | input | 1 | Host direction, 1 = read (strobe mode 1) |
| h_ds_n | input | 1 | Host data strobe (strobe mode 1) |
| h_ale | input | 1 | Address latch enable (address mode 1) |
| h_addr | input | AW | Dedicated host address (address mode 0) |
| h_bus_i | input | DW | Host bus, input side |
| h_bus_o | output | DW | Host bus, read data |
| h_bus_oe | output | 1 | Host bus output enable during reads |
| h_ack | output | 1 | Access acknowledge |
| c_addr | input | AW | Core register address |
| c_wr | input | 1 | Core write strobe |
| c_rd | input | 1 | Core read strobe |
| c_wdata | input | DW | Core write data |
| c_rdata | output | DW | Core read data |
| c_in_full | output | NEACH | Inbound full flags |
| c_out_full | output | NEACH | Outbound full flags |

## Verification
The bench changes the bus value in the very cycle that `h_ale` falls. It also releases the write strobe while the data is still held. A design that sampled the bus one cycle late would pick up the data word as the address, or would store a stale word. The same register sweep runs under all four mode combinations, and `h_addr` is driven to the wrong value whenever the address is multiplexed. A mode decoder that mixed up pins, or read the dedicated address by mistake, would land writes in the wrong register. Stray strobes without the chip-select, and accesses to the wrong half of the register space, are followed by read-backs. An access that leaked through would show up there as a changed flag or a changed word.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
   typedef enum logic {BUS_SPLIT = 1'b0, BUS_MUXED = 1'b1} bus_mode_e;
   typedef enum logic {STB_RDWR = 1'b0, STB_DIRDS = 1'b1} stb_mode_e;

   typedef struct packed {
      logic ale;
      logic ds_n;
      logic dir;
      logic wr_n;
      logic rd_n;
      logic cs_n;
   } hctl_s;

   localparam hctl_s HCTL_IDLE = '{ale: 1'b0, ds_n: 1'b1, dir: 1'b0,
                                   wr_n: 1'b1, rd_n: 1'b1, cs_n: 1'b1};

   typedef struct packed {
      logic rd_go;
      logic rd_end;
      logic wr_end;
   } hacc_s;
endpackage

// File: rtl/hpi_sync.sv
module hpi_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hpi_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chain[s] <= RST_VAL;
         else if (s == 0) chain[s] <= d;
         else             chain[s] <= chain[(s > 0) ? s - 1 : 0];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hpi_front.sv
module hpi_front import hpi_pkg::*; #(
   parameter int DW = 16,
   parameter int AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_mode,
   input  logic          stb_mode,
   input  hctl_s         ctl,
   input  logic [AW-1:0] addr_al,
   input  logic [DW-1:0] bus_al,
   output hacc_s         acc,
   output logic [AW-1:0] acc_addr,
   output logic [DW-1:0] wdata,
   output logic          ack,
   output logic          oe
);
   logic          rd_act, wr_act, rd_act_d, wr_act_d;
   logic          ale_d, go_d, rdgo_d;
   logic          any_start, rd_start, any_end;
   logic [DW-1:0] bus_prev;
   logic [AW-1:0] mux_addr;

   always_comb begin
      if (stb_mode == STB_DIRDS) begin
         rd_act = !ctl.cs_n && !ctl.ds_n && ctl.dir;
         wr_act = !ctl.cs_n && !ctl.ds_n && !ctl.dir;
      end else begin
         rd_act = !ctl.cs_n && !ctl.rd_n;
         wr_act = !ctl.cs_n && !ctl.wr_n;
      end
   end

   assign rd_start   = rd_act && !rd_act_d;
   assign any_start  = rd_start || (wr_act && !wr_act_d);
   assign acc.rd_end = !rd_act && rd_act_d;
   assign acc.wr_end = !wr_act && wr_act_d;
   assign acc.rd_go  = rdgo_d;
   assign any_end    = acc.rd_end || acc.wr_end;
   assign wdata      = bus_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_act_d <= 1'b0;
         wr_act_d <= 1'b0;
         ale_d    <= 1'b0;
         go_d     <= 1'b0;
         rdgo_d   <= 1'b0;
         bus_prev <= '0;
         mux_addr <= '0;
         acc_addr <= '0;
         ack      <= 1'b0;
         oe       <= 1'b0;
      end else begin
         rd_act_d <= rd_act;
         wr_act_d <= wr_act;
         ale_d    <= ctl.ale;
         bus_prev <= bus_al;
         go_d     <= any_start;
         rdgo_d   <= rd_start;
         if (ale_d && !ctl.ale) mux_addr <= bus_prev[AW-1:0];
         if (any_start)
            acc_addr <= (bus_mode == BUS_MUXED) ? mux_addr : addr_al;
         if (any_end)   ack <= 1'b0;
         else if (go_d) ack <= 1'b1;
         if (acc.rd_end)  oe <= 1'b0;
         else if (rdgo_d) oe <= 1'b1;
      end
   end

   p_ack_in_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (rd_act || wr_act || rd_act_d || wr_act_d));
   p_oe_needs_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> ack);
   p_no_ack_idle_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.cs_n && $past(ctl.cs_n)) |-> !ack);
endmodule

// File: rtl/hpi_regs.sv
module hpi_regs import hpi_pkg::*; #(
   parameter int DW    = 16,
   parameter int NEACH = 4,
   parameter int AW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  hacc_s            acc,
   input  logic [AW-1:0]    acc_addr,
   input  logic [DW-1:0]    wdata,
   input  logic [AW-1:0]    c_addr,
   input  logic             c_wr,
   input  logic             c_rd,
   input  logic [DW-1:0]    c_wdata,
   output logic [DW-1:0]    c_rdata,
   output logic [DW-1:0]    h_rdata,
   output logic [NEACH-1:0] in_full,
   output logic [NEACH-1:0] out_full
);
   localparam int IW = AW - 1;

   logic [DW-1:0] in_mem  [NEACH];
   logic [DW-1:0] out_mem [NEACH];
   logic [IW-1:0] c_idx, h_idx;

   assign c_idx   = c_addr[IW-1:0];
   assign h_idx   = acc_addr[IW-1:0];
   assign c_rdata = c_addr[AW-1] ? out_mem[c_idx] : in_mem[c_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         h_rdata <= '0;
      else if (acc.rd_go) h_rdata <= acc_addr[AW-1] ? out_mem[h_idx] : in_mem[h_idx];
   end

   for (genvar i = 0; i < NEACH; i++) begin : g_reg
      localparam logic [AW-1:0] A_IN  = AW'(i);
      localparam logic [AW-1:0] A_OUT = AW'(NEACH + i);
      logic h_set, c_clr, c_set, h_clr;

      assign h_set = acc.wr_end && (acc_addr == A_IN);
      assign c_clr = c_rd && (c_addr == A_IN);
      assign c_set = c_wr && (c_addr == A_OUT);
      assign h_clr = acc.rd_end && (acc_addr == A_OUT);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            in_mem[i]   <= '0;
            out_mem[i]  <= '0;
            in_full[i]  <= 1'b0;
            out_full[i] <= 1'b0;
         end else begin
            if (h_set) in_mem[i]  <= wdata;
            if (c_set) out_mem[i] <= c_wdata;
            if (h_set)      in_full[i] <= 1'b1;
            else if (c_clr) in_full[i] <= 1'b0;
            if (c_set)      out_full[i] <= 1'b1;
            else if (h_clr) out_full[i] <= 1'b0;
         end
      end

      p_in_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (acc.wr_end && acc_addr == A_IN) |=> in_full[i]);
      p_in_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (c_rd && c_addr == A_IN && !(acc.wr_end && acc_addr == A_IN)) |=> !in_full[i]);
      p_out_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (c_wr && c_addr == A_OUT) |=> out_full[i]);
      p_out_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (acc.rd_end && acc_addr == A_OUT && !(c_wr && c_addr == A_OUT)) |=> !out_full[i]);
      p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (acc.wr_end && acc_addr == A_OUT && !(c_wr && c_addr == A_OUT)) |=> $stable(out_mem[i]));
      p_in_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (c_wr && c_addr == A_IN && !(acc.wr_end && acc_addr == A_IN)) |=> $stable(in_mem[i]));
   end

   p_flags_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (in_full == '0 && out_full == '0));
endmodule

// File: rtl/host_mailbox_port.sv
module host_mailbox_port import hpi_pkg::*; #(
   parameter int DW    = 16,
   parameter int NEACH = 4,
   parameter int SYNC  = 2,
   localparam int AW   = $clog2(2 * NEACH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_mode_i,
   input  logic             stb_mode_i,
   input  logic             h_cs_n,
   input  logic             h_rd_n,
   input  logic             h_wr_n,
   input  logic             h_dir,
   input  logic             h_ds_n,
   input  logic             h_ale,
   input  logic [AW-1:0]    h_addr,
   input  logic [DW-1:0]    h_bus_i,
   output logic [DW-1:0]    h_bus_o,
   output logic             h_bus_oe,
   output logic             h_ack,
   input  logic [AW-1:0]    c_addr,
   input  logic             c_wr,
   input  logic             c_rd,
   input  logic [DW-1:0]    c_wdata,
   output logic [DW-1:0]    c_rdata,
   output logic [NEACH-1:0] c_in_full,
   output logic [NEACH-1:0] c_out_full
);
   if (!(DW == 8 || DW == 16)) begin : g_bad_dw
      $error("host_mailbox_port: DW must be 8 or 16");
   end
   if (NEACH < 2 || (NEACH & (NEACH - 1)) != 0) begin : g_bad_neach
      $error("host_mailbox_port: NEACH must be a power of two, at least 2");
   end
   if (AW > DW) begin : g_bad_aw
      $error("host_mailbox_port: address does not fit on the bus");
   end

   hctl_s         ctl_raw, ctl_q;
   logic [AW-1:0] addr_al;
   logic [DW-1:0] bus_al;
   hacc_s         acc;
   logic [AW-1:0] acc_addr;
   logic [DW-1:0] wdata;

   assign ctl_raw = '{ale: h_ale, ds_n: h_ds_n, dir: h_dir,
                      wr_n: h_wr_n, rd_n: h_rd_n, cs_n: h_cs_n};

   hpi_sync #(.W($bits(hctl_s)), .STAGES(SYNC), .RST_VAL(HCTL_IDLE)) u_ctl_sync (
      .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_q));
   hpi_sync #(.W(AW), .STAGES(SYNC), .RST_VAL('0)) u_addr_dly (
      .clk(clk), .rst_n(rst_n), .d(h_addr), .q(addr_al));
   hpi_sync #(.W(DW), .STAGES(SYNC), .RST_VAL('0)) u_bus_dly (
      .clk(clk), .rst_n(rst_n), .d(h_bus_i), .q(bus_al));

   hpi_front #(.DW(DW), .AW(AW)) u_front (
      .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode_i), .stb_mode(stb_mode_i),
      .ctl(ctl_q), .addr_al(addr_al), .bus_al(bus_al), .acc(acc),
      .acc_addr(acc_addr), .wdata(wdata), .ack(h_ack), .oe(h_bus_oe));

   hpi_regs #(.DW(DW), .NEACH(NEACH), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .acc(acc), .acc_addr(acc_addr), .wdata(wdata),
      .c_addr(c_addr), .c_wr(c_wr), .c_rd(c_rd), .c_wdata(c_wdata),
      .c_rdata(c_rdata), .h_rdata(h_bus_o), .in_full(c_in_full),
      .out_full(c_out_full));
endmodule

// File: tb/host_mailbox_port_bench.sv
module host_mailbox_port_bench;
   localparam int DW = 16;
   localparam int NE = 4;
   localparam int AW = 3;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0, bus_mode = 1'b0, stb_mode = 1'b0;
   logic h_cs_n = 1'b1, h_rd_n = 1'b1, h_wr_n = 1'b1, h_dir = 1'b0, h_ds_n = 1'b1, h_ale = 1'b0;
   logic [AW-1:0] h_addr = '0, c_addr = '0;
   logic [DW-1:0] h_bus_i = '0, h_bus_o, c_wdata = '0, c_rdata;
   logic h_bus_oe, h_ack, c_wr = 1'b0, c_rd = 1'b0;
   logic [NE-1:0] c_in_full, c_out_full;

   host_mailbox_port #(.DW(DW), .NEACH(NE), .SYNC(2)) u_host_mailbox_port (
      .clk(clk), .rst_n(rst_n), .bus_mode_i(bus_mode), .stb_mode_i(stb_mode),
      .h_cs_n(h_cs_n), .h_rd_n(h_rd_n), .h_wr_n(h_wr_n), .h_dir(h_dir),
      .h_ds_n(h_ds_n), .h_ale(h_ale), .h_addr(h_addr), .h_bus_i(h_bus_i),
      .h_bus_o(h_bus_o), .h_bus_oe(h_bus_oe), .h_ack(h_ack), .c_addr(c_addr),
      .c_wr(c_wr), .c_rd(c_rd), .c_wdata(c_wdata), .c_rdata(c_rdata),
      .c_in_full(c_in_full), .c_out_full(c_out_full));

   int n_chk = 0, n_err = 0;
   bit done = 0;
   logic [DW-1:0] exp_in [NE];
   logic [DW-1:0] exp_out [NE];
   logic [NE-1:0] exp_inf = '0, exp_outf = '0;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic addr_phase(input int a, input logic [DW-1:0] next_bus);
      if (bus_mode) begin
         h_addr  = AW'(~a);
         h_bus_i = DW'(a);
         h_ale   = 1'b1;
         cyc(4);
         h_ale   = 1'b0;
         h_bus_i = next_bus;
         cyc(2);
      end else begin
         h_addr  = AW'(a);
         h_bus_i = next_bus;
         cyc(1);
      end
   endtask

   task automatic hwrite(input int a, input logic [DW-1:0] d, input string req, input bit use_cs);
      addr_phase(a, d);
      if (stb_mode) begin h_dir = 1'b0; cyc(1); end
      h_cs_n = !use_cs;
      if (stb_mode) h_ds_n = 1'b0; else h_wr_n = 1'b0;
      cyc(6);
      chk(req, "ack during write", h_ack, use_cs);
      h_ds_n = 1'b1; h_wr_n = 1'b1; h_cs_n = 1'b1;
      cyc(6);
      chk("R6", "ack after write", h_ack, 0);
   endtask

   task automatic hread(input int a, output logic [DW-1:0] d, input string req);
      addr_phase(a, 16'h0BAD);
      if (stb_mode) begin h_dir = 1'b1; cyc(1); end
      h_cs_n = 1'b0;
      if (stb_mode) h_ds_n = 1'b0; else h_rd_n = 1'b0;
      cyc(6);
      chk("R6", "ack during read", h_ack, 1);
      chk("R6", "oe during read", h_bus_oe, 1);
      d = h_bus_o;
      h_ds_n = 1'b1; h_rd_n = 1'b1; h_cs_n = 1'b1;
      cyc(6);
      chk(req, "ack after read", h_ack, 0);
      chk("R6", "oe after read", h_bus_oe, 0);
      h_dir = 1'b0;
   endtask

   task automatic cwrite(input int a, input logic [DW-1:0] d);
      c_addr = AW'(a); c_wdata = d; c_wr = 1'b1;
      cyc(1);
      c_wr = 1'b0;
      cyc(1);
   endtask

   task automatic cread(input int a, output logic [DW-1:0] d);
      c_addr = AW'(a); c_rd = 1'b1;
      #1 d = c_rdata;
      cyc(1);
      c_rd = 1'b0;
      cyc(1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d, v;
      string req;
      cyc(3);
      chk("R1", "in flags in reset", c_in_full, 0);
      chk("R1", "out flags in reset", c_out_full, 0);
      chk("R1", "ack in reset", h_ack, 0);
      chk("R1", "oe in reset", h_bus_oe, 0);
      rst_n = 1'b1;
      cyc(2);

      // R2/R3/R4: inbound sweep over every mode combination
      for (int m = 0; m < 4; m++) begin
         bus_mode = m[1]; stb_mode = m[0];
         req = (m == 0) ? "R2" : (m[1] ? "R3" : "R4");
         for (int i = 0; i < NE; i++) begin
            d = DW'((m * 16'h1111) ^ (i * 16'h0F0F) ^ 16'h5A5A);
            hwrite(i, d, req, 1'b1);
            exp_in[i] = d; exp_inf[i] = 1'b1;
            chk(req, "inbound flags", c_in_full, exp_inf);
         end
         for (int i = 0; i < NE; i++) begin
            cread(i, v);
            chk(req, "inbound data", v, exp_in[i]);
            exp_inf[i] = 1'b0;
            chk("R8", "inbound flag clear", c_in_full, exp_inf);
         end
      end

      // R7/R8: outbound sweep over every mode combination
      for (int m = 0; m < 4; m++) begin
         bus_mode = m[1]; stb_mode = m[0];
         for (int i = 0; i < NE; i++) begin
            d = DW'((i * 16'h2468) + (m * 16'h0101) + 16'h1357);
            cwrite(NE + i, d);
            exp_out[i] = d; exp_outf[i] = 1'b1;
            chk("R8", "outbound flag set", c_out_full, exp_outf);
            hread(NE + i, v, "R7");
            chk("R7", "outbound data", v, exp_out[i]);
            exp_outf[i] = 1'b0;
            chk("R7", "outbound flag clear", c_out_full, exp_outf);
         end
      end

      // R7: host read of an inbound register keeps its flag
      bus_mode = 1'b0; stb_mode = 1'b0;
      hwrite(2, 16'hC0DE, "R2", 1'b1);
      exp_in[2] = 16'hC0DE; exp_inf[2] = 1'b1;
      hread(2, v, "R7");
      chk("R7", "inbound readback", v, 16'hC0DE);
      chk("R7", "inbound flag kept", c_in_full, exp_inf);
      cread(2, v);
      exp_inf[2] = 1'b0;

      // R5: strobe without chip-select, chip-select without strobe
      hwrite(1, 16'hDEAD, "R5", 1'b0);
      chk("R5", "flags after stray strobe", c_in_full, exp_inf);
      h_cs_n = 1'b0; cyc(6);
      chk("R5", "ack with cs only", h_ack, 0);
      h_cs_n = 1'b1; cyc(4);
      cread(1, v);
      chk("R5", "data after stray strobe", v, exp_in[1]);

      // R4: in direction mode the separate strobes are ignored
      stb_mode = 1'b1;
      h_addr = AW'(3); h_bus_i = 16'hBEEF; cyc(1);
      h_cs_n = 1'b0; h_wr_n = 1'b0; cyc(6);
      chk("R4", "ack from ignored wr_n", h_ack, 0);
      h_wr_n = 1'b1; h_cs_n = 1'b1; cyc(6);
      chk("R4", "flags after ignored wr_n", c_in_full, exp_inf);
      cread(3, v);
      chk("R4", "data after ignored wr_n", v, exp_in[3]);
      stb_mode = 1'b0;

      // R9: writes into the wrong half are dropped
      hwrite(NE + 1, 16'hFACE, "R9", 1'b1);
      chk("R9", "out flags after host write", c_out_full, exp_outf);
      chk("R9", "in flags after host write", c_in_full, exp_inf);
      hread(NE + 1, v, "R9");
      chk("R9", "outbound kept", v, exp_out[1]);
      cwrite(1, 16'h7777);
      chk("R9", "in flags after core write", c_in_full, exp_inf);
      cread(1, v);
      chk("R9", "inbound kept", v, exp_in[1]);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule